// File: doc/BRIEF.md
# Extended Multiblock Alignment Tracker

This block follows the sync-header side channel of one receive lane on a 64b/66b converter link. Every received 66-bit block has a 2-bit header, and the header gives one sync bit. The block puts these bits into a 32-bit sync word for each 32-block multiblock. It finds the end-of-multiblock and end-of-extended-multiblock markers in that word and runs a three-state alignment machine: search, hunt and lock. It also takes out the 12-bit CRC field that each sync word carries for the multiblock before it. It compares that field with a CRC that logic outside the block computes and supplies.

A lane controller instantiates one tracker per lane. It gives the tracker the lane enable, the PHY header-alignment flag, a strobe for each valid block, and the number of multiblocks per extended multiblock, written as E-1. The tracker returns its one-hot state, a strobe at each multiblock boundary and at each extended-multiblock boundary, the last received CRC field, and four error pulses. A mask bit can suppress each error pulse on its own.

Sync word layout: the first sync bit of a multiblock lands in word bit 31 and the last in bit 0. Bits [4:0] are the end-of-multiblock pattern 00001. Bit 5 is the extended-multiblock end flag. Bits [31:20] hold the CRC field.

Top module: `emb_align_tracker`

## Requirements
- R1: `emb_state` is one-hot. Search = 3'b001, hunt = 3'b010, lock = 3'b100. After reset the state is search.
- R2: While `lane_en` is low the state is search on the next cycle. The machine leaves search only for hunt. It does so on a valid block, with the lane enabled and header-aligned, when the last 32 sync bits have bits [4:0] = 00001 and bit 5 = 1.
- R3: If `hdr_locked` is low in a cycle, the state is search on the next cycle, whatever the state was.
- R4: In hunt, every multiblock end (the 32nd valid block after the previous end or after entry) is checked. It is correct when bits [4:0] = 00001 and bit 5 equals "this is multiblock E-1 of the extended multiblock", with the count starting at 0 after entry. After 4 correct ends in a row the state becomes lock. One incorrect end sends it back to search.
- R5: In lock, 8 incorrect multiblock ends in a row send the state to search. A correct end clears the run.
- R6: Header 2'b01 gives sync bit 0 and 2'b10 gives sync bit 1. On a valid block of an active lane, header 2'b00 or 2'b11 raises `err_hdr` for one cycle on the next cycle. The sync bit used is always `sync_hdr[1]`.
- R7: At a multiblock end in hunt or lock, a bad [4:0] pattern raises `err_eomb`. A bit 5 that does not match the expected boundary raises `err_eoemb`. Both pulses appear on the next cycle.
- R8: At each multiblock end in hunt or lock, `crc_rx` loads bits [31:20]. If that field differs from `crc_calc`, `err_crc` pulses. This check is skipped for the first multiblock after leaving search.
- R9: `err_mask` bit 0 suppresses `err_hdr`, bit 1 `err_eomb`, bit 2 `err_eoemb` and bit 3 `err_crc`.
- R10: `eomb_pulse` fires one cycle after each multiblock end in hunt or lock. `eoemb_pulse` fires with it when that multiblock was index E-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_en | input | 1 | Lane enable |
| hdr_locked | input | 1 | PHY sync-header alignment reached |
| blk_valid | input | 1 | A block and its header are present this cycle |
| sync_hdr | input | 2 | Sync header of the present block |
| emb_len_m1 | input | EMB_W | Multiblocks per extended multiblock, minus 1 |
| crc_calc | input | 12 | Externally computed CRC of the previous multiblock |
| err_mask | input | 4 | Error suppression bits: hdr, eomb, eoemb, crc |
| emb_state | output | 3 | One-hot alignment state |
| eomb_pulse | output | 1 | Multiblock boundary strobe |
| eoemb_pulse | output | 1 | Extended-multiblock boundary strobe |
| crc_rx | output | 12 | CRC field from the latest sync word |
| err_hdr | output | 1 | Invalid sync header pulse |
| err_eomb | output | 1 | Invalid end-of-multiblock pulse |
| err_eoemb | output | 1 | Invalid end-of-extended-multiblock pulse |
| err_crc | output | 1 | CRC mismatch pulse |

## Verification
The assertions assume three things about the inputs. First, `emb_len_m1` and `err_mask` stay constant for the whole multiblock in which they are used. Second, `crc_calc` is stable on the cycle of a multiblock end. Third, a loss of `hdr_locked` or `lane_en` may happen at any time. The stimulus changes E only while the lane is disabled. It holds each CRC value for a whole generated word and drops header alignment at random single cycles. It sends sync words with the correct layout and corrupts markers, CRCs and headers at controlled rates. Some phases turn clean traffic into solid corruption after lock, so that lock loss is reached.

// File: rtl/emb_pkg.sv
// Package: shared state type and sync-word layout constants for the
// extended multiblock alignment tracker. Assumes a 32-block multiblock.
package emb_pkg;

    typedef enum logic [2:0] {
        EMB_INIT = 3'b001,
        EMB_HUNT = 3'b010,
        EMB_LOCK = 3'b100
    } emb_state_t;

    localparam int SW_BITS   = 32;       // sync bits per multiblock
    localparam int CRC_BITS  = 12;       // CRC field width
    localparam int CRC_LSB   = 20;       // CRC field occupies [31:20]
    localparam int FLAG_POS  = 5;        // extended multiblock end flag
    localparam int MARK_BITS = 5;        // end-of-multiblock pattern width
    localparam logic [MARK_BITS-1:0] EOMB_PATTERN = 5'b00001;

endpackage

// File: rtl/emb_hdr_shift.sv
// Header decoder and sync-word shift register. Turns each valid 2-bit
// header into one sync bit (MSB first) and flags invalid headers.
// Assumes sync_hdr is meaningful only when blk_valid is high.
module emb_hdr_shift
    import emb_pkg::*;
#(
    parameter int WORD_BITS = SW_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 blk_valid,
    input  logic [1:0]           sync_hdr,
    input  logic                 mask_hdr,
    output logic [WORD_BITS-1:0] next_word,
    output logic                 err_hdr
);

    logic [WORD_BITS-1:0] shreg;
    logic                 hdr_bad;

    // Word as it stands once the present block's bit is appended.
    always_comb begin
        next_word = {shreg[WORD_BITS-2:0], sync_hdr[1]};
        hdr_bad   = (sync_hdr == 2'b00) || (sync_hdr == 2'b11);
    end

    // Shift in one sync bit per valid block; clear while lane inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            err_hdr <= 1'b0;
        end else begin
            err_hdr <= active && blk_valid && hdr_bad && !mask_hdr;
            if (!active)
                shreg <= '0;
            else if (blk_valid)
                shreg <= next_word;
        end
    end

    p_hdr_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_hdr |-> $past(blk_valid) && $past(active));

    p_hdr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_hdr |=> !err_hdr);

endmodule

// File: rtl/emb_word_eval.sv
// Combinational sync-word evaluation: marker pattern, boundary flag
// against the expected position, CRC field extraction and comparison.
// Assumes mb_idx never exceeds emb_last.
module emb_word_eval
    import emb_pkg::*;
#(
    parameter int WORD_BITS = SW_BITS,
    parameter int EMB_W     = 5
) (
    input  logic [WORD_BITS-1:0] word,
    input  logic [EMB_W-1:0]     mb_idx,
    input  logic [EMB_W-1:0]     emb_last,
    input  logic [CRC_BITS-1:0]  crc_calc,
    output logic                 eomb_ok,
    output logic                 emb_flag,
    output logic                 exp_last,
    output logic                 flag_ok,
    output logic [CRC_BITS-1:0]  crc_field,
    output logic                 crc_match
);

    // Decode the marker fields and compare against expectations.
    always_comb begin
        eomb_ok   = (word[MARK_BITS-1:0] == EOMB_PATTERN);
        emb_flag  = word[FLAG_POS];
        exp_last  = (mb_idx == emb_last);
        flag_ok   = (emb_flag == exp_last);
        crc_field = word[CRC_LSB +: CRC_BITS];
        crc_match = (crc_field == crc_calc);
    end

endmodule

// File: rtl/emb_fsm.sv
// Alignment state machine with block, multiblock and run counters.
// Produces boundary strobes, marker/CRC error pulses and the CRC field.
// Assumes emb_last and err masks are steady within a multiblock.
module emb_fsm
    import emb_pkg::*;
#(
    parameter int EMB_W     = 5,
    parameter int HUNT_GOOD = 4,
    parameter int LOCK_BAD  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                blk_valid,
    input  logic                eomb_ok,
    input  logic                emb_flag,
    input  logic                exp_last,
    input  logic                flag_ok,
    input  logic [CRC_BITS-1:0] crc_field,
    input  logic                crc_match,
    input  logic [3:1]          err_mask,
    output emb_state_t          state,
    output logic [EMB_W-1:0]    mb_idx,
    output logic                eomb_pulse,
    output logic                eoemb_pulse,
    output logic [CRC_BITS-1:0] crc_rx,
    output logic                err_eomb,
    output logic                err_eoemb,
    output logic                err_crc
);

    localparam int BLK_W  = $clog2(SW_BITS);
    localparam int GOOD_W = $clog2(HUNT_GOOD + 1);
    localparam int BAD_W  = $clog2(LOCK_BAD + 1);
    localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(SW_BITS - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(HUNT_GOOD - 1);
    localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(LOCK_BAD - 1);

    emb_state_t        nxt;
    logic [BLK_W-1:0]  blk_cnt;
    logic [GOOD_W-1:0] good_cnt;
    logic [BAD_W-1:0]  bad_cnt;
    logic              first_mb;
    logic              mb_end;
    logic              correct;

    // Multiblock end detection and per-end verdict.
    always_comb begin
        mb_end  = blk_valid && (state != EMB_INIT) && (blk_cnt == BLK_LAST);
        correct = eomb_ok && flag_ok;
    end

    // Next-state selection for the search/hunt/lock machine.
    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = EMB_INIT;
        end else begin
            unique case (state)
                EMB_INIT: if (blk_valid && eomb_ok && emb_flag) nxt = EMB_HUNT;
                EMB_HUNT: if (mb_end) begin
                    if (!correct)                  nxt = EMB_INIT;
                    else if (good_cnt == GOOD_LAST) nxt = EMB_LOCK;
                end
                EMB_LOCK: if (mb_end && !correct && bad_cnt == BAD_LAST)
                    nxt = EMB_INIT;
                default: nxt = EMB_INIT;
            endcase
        end
    end

    // State, counters, strobes and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= EMB_INIT;
            blk_cnt     <= '0;
            mb_idx      <= '0;
            good_cnt    <= '0;
            bad_cnt     <= '0;
            first_mb    <= 1'b1;
            crc_rx      <= '0;
            eomb_pulse  <= 1'b0;
            eoemb_pulse <= 1'b0;
            err_eomb    <= 1'b0;
            err_eoemb   <= 1'b0;
            err_crc     <= 1'b0;
        end else begin
            state       <= nxt;
            eomb_pulse  <= 1'b0;
            eoemb_pulse <= 1'b0;
            err_eomb    <= 1'b0;
            err_eoemb   <= 1'b0;
            err_crc     <= 1'b0;
            if (!active || state == EMB_INIT) begin
                blk_cnt  <= '0;
                mb_idx   <= '0;
                good_cnt <= '0;
                bad_cnt  <= '0;
                first_mb <= 1'b1;
            end else if (mb_end) begin
                blk_cnt     <= '0;
                mb_idx      <= exp_last ? '0 : mb_idx + 1'b1;
                first_mb    <= 1'b0;
                crc_rx      <= crc_field;
                eomb_pulse  <= 1'b1;
                eoemb_pulse <= exp_last;
                err_eomb    <= !eomb_ok && !err_mask[1];
                err_eoemb   <= !flag_ok && !err_mask[2];
                err_crc     <= !first_mb && !crc_match && !err_mask[3];
                if (state == EMB_HUNT)
                    good_cnt <= correct ? good_cnt + 1'b1 : '0;
                if (state == EMB_LOCK)
                    bad_cnt <= correct ? '0 : bad_cnt + 1'b1;
            end else if (blk_valid) begin
                blk_cnt <= blk_cnt + 1'b1;
            end
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

    p_init_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EMB_INIT) |=> (state != EMB_LOCK));

    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == EMB_INIT));

    p_hunt_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EMB_HUNT && !mb_end) |=> (state != EMB_LOCK));

    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EMB_LOCK && active && !mb_end) |=> (state == EMB_LOCK));

    p_crc_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_mask[3] |=> !err_crc);

    p_eoemb_in_eomb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eoemb_pulse |-> eomb_pulse);

endmodule

// File: rtl/emb_align_tracker.sv
// Top: per-lane extended multiblock alignment tracker. Combines lane
// enable and PHY header alignment into one activity term, and wires the
// header shifter, word evaluator and state machine together.
// Assumes one sync header per valid block and an external CRC source.
module emb_align_tracker
    import emb_pkg::*;
#(
    parameter int EMB_W     = 5,
    parameter int HUNT_GOOD = 4,
    parameter int LOCK_BAD  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lane_en,
    input  logic                hdr_locked,
    input  logic                blk_valid,
    input  logic [1:0]          sync_hdr,
    input  logic [EMB_W-1:0]    emb_len_m1,
    input  logic [CRC_BITS-1:0] crc_calc,
    input  logic [3:0]          err_mask,
    output logic [2:0]          emb_state,
    output logic                eomb_pulse,
    output logic                eoemb_pulse,
    output logic [CRC_BITS-1:0] crc_rx,
    output logic                err_hdr,
    output logic                err_eomb,
    output logic                err_eoemb,
    output logic                err_crc
);

    logic                active;
    logic [SW_BITS-1:0]  word;
    logic [EMB_W-1:0]    mb_idx;
    logic                eomb_ok, emb_flag, exp_last, flag_ok, crc_match;
    logic [CRC_BITS-1:0] crc_field;
    emb_state_t          state;

    // Lane takes part only when enabled and header-aligned.
    always_comb active = lane_en && hdr_locked;

    emb_hdr_shift #(.WORD_BITS(SW_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .blk_valid (blk_valid),
        .sync_hdr  (sync_hdr),
        .mask_hdr  (err_mask[0]),
        .next_word (word),
        .err_hdr   (err_hdr)
    );

    emb_word_eval #(.WORD_BITS(SW_BITS), .EMB_W(EMB_W)) u_eval (
        .word      (word),
        .mb_idx    (mb_idx),
        .emb_last  (emb_len_m1),
        .crc_calc  (crc_calc),
        .eomb_ok   (eomb_ok),
        .emb_flag  (emb_flag),
        .exp_last  (exp_last),
        .flag_ok   (flag_ok),
        .crc_field (crc_field),
        .crc_match (crc_match)
    );

    emb_fsm #(.EMB_W(EMB_W), .HUNT_GOOD(HUNT_GOOD), .LOCK_BAD(LOCK_BAD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .blk_valid   (blk_valid),
        .eomb_ok     (eomb_ok),
        .emb_flag    (emb_flag),
        .exp_last    (exp_last),
        .flag_ok     (flag_ok),
        .crc_field   (crc_field),
        .crc_match   (crc_match),
        .err_mask    (err_mask[3:1]),
        .state       (state),
        .mb_idx      (mb_idx),
        .eomb_pulse  (eomb_pulse),
        .eoemb_pulse (eoemb_pulse),
        .crc_rx      (crc_rx),
        .err_eomb    (err_eomb),
        .err_eoemb   (err_eoemb),
        .err_crc     (err_crc)
    );

    // Export the one-hot state as a plain vector.
    always_comb emb_state = state;

endmodule

// File: tb/emb_align_tracker_bench.sv
module emb_align_tracker_bench;
    localparam int EMB_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lane_en = 1'b0, hdr_locked = 1'b0, blk_valid = 1'b0;
    logic [1:0] sync_hdr = 2'b01;
    logic [EMB_W-1:0] emb_len_m1 = '0;
    logic [11:0] crc_calc = '0;
    logic [3:0] err_mask = '0;
    logic [2:0] emb_state;
    logic eomb_pulse, eoemb_pulse, err_hdr, err_eomb, err_eoemb, err_crc;
    logic [11:0] crc_rx;

    always #2 clk = ~clk;

    emb_align_tracker #(.EMB_W(EMB_W)) u_emb_align_tracker (
        .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .hdr_locked(hdr_locked),
        .blk_valid(blk_valid), .sync_hdr(sync_hdr), .emb_len_m1(emb_len_m1),
        .crc_calc(crc_calc), .err_mask(err_mask), .emb_state(emb_state),
        .eomb_pulse(eomb_pulse), .eoemb_pulse(eoemb_pulse), .crc_rx(crc_rx),
        .err_hdr(err_hdr), .err_eomb(err_eomb), .err_eoemb(err_eoemb),
        .err_crc(err_crc)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    logic [2:0]  m_state;
    logic [31:0] m_sh;
    int          m_blk, m_mb, m_good, m_bad;
    bit          m_first;
    logic [11:0] m_crc_rx;
    bit m_eomb, m_eoemb, m_ehdr, m_eeomb, m_eeoemb, m_ecrc;
    bit prev_off, prev_unl;
    bit saw_lock, saw_lock_loss;
    logic [2:0] obs_prev;

    // Generator state
    logic [31:0] gword;
    int gpos, gmb, e_cur, corrupt_den;
    bit corrupt_all;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit hdr_invalid(input logic [1:0] h);
        return (h == 2'b00) || (h == 2'b11);
    endfunction

    task automatic model_step();
        bit act, corr, expl;
        logic [31:0] w;
        int e;
        m_eomb = 0; m_eoemb = 0; m_ehdr = 0; m_eeomb = 0; m_eeoemb = 0; m_ecrc = 0;
        prev_off = !lane_en; prev_unl = !hdr_locked;
        e = int'(emb_len_m1) + 1;
        act = lane_en && hdr_locked;
        if (!rst_n) begin
            m_state = 3'b001; m_sh = 0; m_blk = 0; m_mb = 0; m_good = 0; m_bad = 0;
            m_first = 1; m_crc_rx = 0;
        end else if (!act) begin
            m_state = 3'b001; m_sh = 0; m_blk = 0; m_mb = 0; m_good = 0; m_bad = 0; m_first = 1;
        end else if (m_state == 3'b001) begin
            m_blk = 0; m_mb = 0; m_good = 0; m_bad = 0; m_first = 1;
            if (blk_valid) begin
                w = {m_sh[30:0], sync_hdr[1]};
                m_ehdr = hdr_invalid(sync_hdr) && !err_mask[0];
                m_sh = w;
                if (w[4:0] == 5'b00001 && w[5]) m_state = 3'b010;
            end
        end else if (blk_valid) begin
            w = {m_sh[30:0], sync_hdr[1]};
            m_ehdr = hdr_invalid(sync_hdr) && !err_mask[0];
            m_sh = w;
            if (m_blk == 31) begin
                expl = (m_mb == e - 1);
                corr = (w[4:0] == 5'b00001) && (w[5] == expl);
                m_eomb = 1; m_eoemb = expl;
                m_eeomb = (w[4:0] != 5'b00001) && !err_mask[1];
                m_eeoemb = (w[5] != expl) && !err_mask[2];
                m_ecrc = !m_first && (w[31:20] != crc_calc) && !err_mask[3];
                m_crc_rx = w[31:20];
                m_first = 0; m_blk = 0;
                m_mb = expl ? 0 : m_mb + 1;
                if (m_state == 3'b010) begin
                    if (!corr) m_state = 3'b001;
                    else begin
                        m_good++;
                        if (m_good == 4) m_state = 3'b100;
                    end
                end else begin
                    if (corr) m_bad = 0;
                    else begin
                        m_bad++;
                        if (m_bad == 8) m_state = 3'b001;
                    end
                end
            end else m_blk++;
        end
    endtask

    task automatic compare();
        string st;
        st = prev_off ? "R2 state" : (prev_unl ? "R3 state" : "R1 state");
        chk(emb_state === m_state, st, emb_state, m_state);
        chk(eomb_pulse === m_eomb, "R10 eomb_pulse", eomb_pulse, m_eomb);
        chk(eoemb_pulse === m_eoemb, "R10 eoemb_pulse", eoemb_pulse, m_eoemb);
        chk(crc_rx === m_crc_rx, "R8 crc_rx", crc_rx, m_crc_rx);
        chk(err_hdr === m_ehdr, err_mask[0] ? "R9 err_hdr" : "R6 err_hdr", err_hdr, m_ehdr);
        chk(err_eomb === m_eeomb, err_mask[1] ? "R9 err_eomb" : "R7 err_eomb", err_eomb, m_eeomb);
        chk(err_eoemb === m_eeoemb, err_mask[2] ? "R9 err_eoemb" : "R7 err_eoemb", err_eoemb, m_eeoemb);
        chk(err_crc === m_ecrc, err_mask[3] ? "R9 err_crc" : "R8 err_crc", err_crc, m_ecrc);
        if (obs_prev == 3'b010 && emb_state == 3'b100) saw_lock = 1;
        if (obs_prev == 3'b100 && emb_state == 3'b001 && !prev_off && !prev_unl) saw_lock_loss = 1;
        obs_prev = emb_state;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic gen_word(input bit bad);
        bit flag;
        logic [11:0] crc;
        flag = (gmb == e_cur - 1);
        gmb = flag ? 0 : gmb + 1;
        crc = 12'($urandom);
        gword = {crc, 14'b0, flag, 5'b00001};
        if (bad) begin
            if ($urandom % 2 == 0) gword[5] = ~gword[5];
            else gword[0] = 1'b0;
        end
        crc_calc = ($urandom % 8 == 0) ? (crc ^ 12'h5a5) : crc;
    endtask

    task automatic drive_block(input int cyc);
        bit b, bad;
        blk_valid = ($urandom % 8 != 0);
        hdr_locked = ($urandom % 700 != 0);
        if (blk_valid) begin
            if (gpos == 0) begin
                bad = corrupt_all || (corrupt_den != 0 && $urandom % corrupt_den == 0);
                gen_word(bad);
            end
            b = gword[31 - gpos];
            gpos = (gpos + 1) % 32;
            if ($urandom % 64 == 0) sync_hdr = b ? 2'b11 : 2'b00;
            else sync_hdr = b ? 2'b10 : 2'b01;
        end else begin
            sync_hdr = 2'($urandom);
        end
    endtask

    initial begin
        int limit;
        limit = 150000;
        repeat (limit) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        obs_prev = 3'b001;
        rst_n = 0;
        repeat (3) cycle();
        @(negedge clk);
        rst_n = 1;
        // Reset state check (R1)
        chk(emb_state === 3'b001, "R1 reset state", emb_state, 3'b001);
        // Disabled lane with a valid marker stream stays in search (R2)
        lane_en = 0; hdr_locked = 1;
        gpos = 0; gmb = 0; e_cur = 1; corrupt_den = 0; corrupt_all = 0;
        for (int i = 0; i < 100; i++) begin
            drive_block(i); hdr_locked = 1;
            cycle();
            chk(emb_state === 3'b001, "R2 disabled lane", emb_state, 3'b001);
        end
        for (int ph = 0; ph < 8; ph++) begin
            lane_en = 0;
            e_cur = (ph % 4) + 1;
            emb_len_m1 = EMB_W'(e_cur - 1);
            err_mask = (ph == 5) ? 4'hf : ((ph == 7) ? 4'h5 : 4'h0);
            corrupt_den = (ph == 0) ? 0 : 32;
            corrupt_all = 0;
            gpos = 0; gmb = 0;
            repeat (5) cycle();
            lane_en = 1;
            for (int i = 0; i < 1400; i++) begin
                if ((ph == 3 || ph == 6) && i == 800) corrupt_all = 1;
                drive_block(i);
                cycle();
            end
        end
        lane_en = 0; blk_valid = 0;
        repeat (3) cycle();
        chk(saw_lock, "R4 hunt reached lock", 32'(saw_lock), 1);
        chk(saw_lock_loss, "R5 lock lost on bad run", 32'(saw_lock_loss), 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule